// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns time-base events into two registered PWM output levels, A and B. A counter outside the block supplies its count value, its direction, and strobes that mark the zero and period points. The block compares the count against two compare values, one per channel. Each channel has its own action-control word. For every event the word names one of four actions: leave the level alone, drive it low, drive it high, or toggle it.

A standing software force can hold either output low or high, whatever the events say. Software writes the force value into a shadow input. A reload-mode field sets when the shadow value becomes the active force: at counter zero, at counter period, at either one, or on every clock. On the edge where a new force value loads, it already controls the output. A typical up-count waveform sets the output high at zero and at period and sets it low on the compare-up match.

Top module: `pwm_action_qual`

## Requirements
- R1: Each 2-bit action code acts on its channel's output register at the clock edge of the event cycle. The codes are 00 hold, 01 low, 10 high and 11 invert.
- R2: Field positions in an action-control word are zero event [1:0], period event [3:2], compare-A-up [5:4] and compare-B-up [9:8]. Channel A uses only [5:4] of the two compare fields, and channel B uses only [9:8]. All other bits have no effect.
- R3: A compare event occurs only when the count equals that channel's compare value and cntUp is 1. An equal count while counting down has no effect.
- R4: When several events fall in one cycle, the output takes the code of the highest-priority event whose code is not 00. The order is compare first, then period, then zero.
- R5: The force field for A is forceWord[1:0] and for B is forceWord[3:2]. Code 01 holds the output low and 10 holds it high, overriding all event actions. Codes 00 and 11 mean no force.
- R6: The reload mode is 00 = load the shadow force at a zero strobe, 01 = at a period strobe, 10 = at either, 11 = every clock. A loaded value sets the output at the same clock edge as the load.
- R7: When no load occurs, changes to forceWord have no effect on the active force or the outputs.
- R8: In reset both outputs are low and no force is active.
- R9: With no event and no active force, each output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntVal | input | CntWidth | Current counter value |
| cntUp | input | 1 | 1 while the counter counts up |
| atZero | input | 1 | Counter-at-zero strobe |
| atPeriod | input | 1 | Counter-at-period strobe |
| cmpA | input | CntWidth | Compare value for channel A |
| cmpB | input | CntWidth | Compare value for channel B |
| actCtlA | input | CtlWidth | Action-control word of channel A |
| actCtlB | input | CtlWidth | Action-control word of channel B |
| forceWord | input | 4 | Shadow software-force value, A in [1:0], B in [3:2] |
| reloadMode | input | 2 | When the shadow force is loaded |
| pwmA | output | 1 | Output level of channel A |
| pwmB | output | 1 | Output level of channel B |

## Verification
Every result is due exactly one clock edge after the inputs that cause it: event actions, force overrides and force loads all land in the output registers on the edge of the strobe cycle. The bench changes inputs on the falling edge and compares outputs at the following falling edge, so each comparison sees the single capturing edge. The sweep covers every zero, period and compare code, every subset of simultaneous events and both starting levels. Separate sequences hold a force across strobes that must not load it, so the deferred reloads show up one strobe late if they misbehave.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ActNone   = 2'b00,
    ActLow    = 2'b01,
    ActHigh   = 2'b10,
    ActToggle = 2'b11
  } aqAct_e;

  typedef enum logic [1:0] {
    RldZero   = 2'b00,
    RldPeriod = 2'b01,
    RldEither = 2'b10,
    RldNow    = 2'b11
  } aqReload_e;

  typedef struct packed {
    logic evZero;
    logic evPrd;
    logic evCmpA;
    logic evCmpB;
    logic loadForce;
  } aqStrobes_t;

  localparam int NumChan  = 2;
  localparam int FieldW   = 2;
  localparam int ZeroLsb  = 0;
  localparam int PrdLsb   = 2;
  localparam int CmpALsb  = 4;
  localparam int CmpBLsb  = 8;
  localparam int UsedBits = 10;

endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CntWidth = 16
) (
  input  logic [CntWidth-1:0] cntVal,
  input  logic                cntUp,
  input  logic                atZero,
  input  logic                atPeriod,
  input  logic [CntWidth-1:0] cmpA,
  input  logic [CntWidth-1:0] cmpB,
  input  logic [1:0]          reloadMode,
  output aqStrobes_t          strobes
);

  logic matchA;
  logic matchB;

  assign matchA = (cntVal == cmpA);
  assign matchB = (cntVal == cmpB);

  always_comb begin
    strobes.evZero = atZero;
    strobes.evPrd  = atPeriod;
    strobes.evCmpA = matchA && cntUp;
    strobes.evCmpB = matchB && cntUp;
    unique case (aqReload_e'(reloadMode))
      RldZero:   strobes.loadForce = atZero;
      RldPeriod: strobes.loadForce = atPeriod;
      RldEither: strobes.loadForce = atZero || atPeriod;
      default:   strobes.loadForce = 1'b1;
    endcase
  end

endmodule

// File: rtl/pwm_aq_datapath.sv
module pwm_aq_datapath
  import pwm_aq_pkg::*;
#(
  parameter int CtlWidth = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  aqStrobes_t                        strobes,
  input  logic [NumChan-1:0][CtlWidth-1:0]  actCtl,
  input  logic [NumChan*FieldW-1:0]         forceWord,
  output logic [NumChan-1:0]                pwmOut
);

  logic [NumChan*FieldW-1:0] activeForce;
  logic [NumChan*FieldW-1:0] nextForce;

  assign nextForce = strobes.loadForce ? forceWord : activeForce;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeForce <= '0;
    else       activeForce <= nextForce;
  end

  assert_force_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadForce |=> $stable(activeForce));

  assert_force_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadForce |=> (activeForce == $past(forceWord)));

  for (genvar ch = 0; ch < NumChan; ch++) begin : gChan
    localparam int CmpLsb   = (ch == 0) ? CmpALsb : CmpBLsb;
    localparam int OtherLsb = (ch == 0) ? CmpBLsb : CmpALsb;

    logic   cmpHit;
    aqAct_e zeroCode, prdCode, cmpCode, chosen;
    logic   evLevel, pwmD, pwmQ;
    logic [FieldW-1:0] forceSel;
    logic   unusedCtl;

    assign cmpHit   = (ch == 0) ? strobes.evCmpA : strobes.evCmpB;
    assign zeroCode = aqAct_e'(actCtl[ch][ZeroLsb +: FieldW]);
    assign prdCode  = aqAct_e'(actCtl[ch][PrdLsb +: FieldW]);
    assign cmpCode  = aqAct_e'(actCtl[ch][CmpLsb +: FieldW]);
    assign unusedCtl = ^{actCtl[ch][CtlWidth-1:UsedBits],
                         actCtl[ch][7:6],
                         actCtl[ch][OtherLsb +: FieldW]};

    always_comb begin
      if (cmpHit && cmpCode != ActNone)                 chosen = cmpCode;
      else if (strobes.evPrd && prdCode != ActNone)     chosen = prdCode;
      else if (strobes.evZero && zeroCode != ActNone)   chosen = zeroCode;
      else                                              chosen = ActNone;
    end

    always_comb begin
      unique case (chosen)
        ActLow:    evLevel = 1'b0;
        ActHigh:   evLevel = 1'b1;
        ActToggle: evLevel = ~pwmQ;
        default:   evLevel = pwmQ;
      endcase
    end

    assign forceSel = nextForce[ch*FieldW +: FieldW];

    always_comb begin
      unique case (aqAct_e'(forceSel))
        ActLow:  pwmD = 1'b0;
        ActHigh: pwmD = 1'b1;
        default: pwmD = evLevel;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pwmQ <= 1'b0;
      else       pwmQ <= pwmD;
    end

    assign pwmOut[ch] = pwmQ;

    assert_force_low_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.loadForce && forceWord[ch*FieldW +: FieldW] == 2'b01) |=> !pwmQ);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.loadForce && !strobes.evZero && !strobes.evPrd && !cmpHit &&
       activeForce[ch*FieldW] == activeForce[ch*FieldW+1]) |=> $stable(pwmQ));

    assert_toggle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.loadForce && strobes.evZero && !strobes.evPrd && !cmpHit &&
       zeroCode == ActToggle &&
       activeForce[ch*FieldW] == activeForce[ch*FieldW+1]) |=> (pwmQ != $past(pwmQ)));
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CntWidth = 16,
  parameter int CtlWidth = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CntWidth-1:0] cntVal,
  input  logic                cntUp,
  input  logic                atZero,
  input  logic                atPeriod,
  input  logic [CntWidth-1:0] cmpA,
  input  logic [CntWidth-1:0] cmpB,
  input  logic [CtlWidth-1:0] actCtlA,
  input  logic [CtlWidth-1:0] actCtlB,
  input  logic [3:0]          forceWord,
  input  logic [1:0]          reloadMode,
  output logic                pwmA,
  output logic                pwmB
);

  aqStrobes_t                       strobes;
  logic [NumChan-1:0]               pwmOut;
  logic [NumChan-1:0][CtlWidth-1:0] actCtl;

  assign actCtl[0] = actCtlA;
  assign actCtl[1] = actCtlB;

  pwm_aq_ctrl #(.CntWidth(CntWidth)) u_ctrl (
    .cntVal     (cntVal),
    .cntUp      (cntUp),
    .atZero     (atZero),
    .atPeriod   (atPeriod),
    .cmpA       (cmpA),
    .cmpB       (cmpB),
    .reloadMode (reloadMode),
    .strobes    (strobes)
  );

  pwm_aq_datapath #(.CtlWidth(CtlWidth)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .actCtl    (actCtl),
    .forceWord (forceWord),
    .pwmOut    (pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

endmodule

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = 16'd0;
  logic        cntUp = 1'b1;
  logic        atZero = 1'b0;
  logic        atPeriod = 1'b0;
  logic [15:0] cmpA = 16'd5;
  logic [15:0] cmpB = 16'd5;
  logic [15:0] actCtlA = 16'd0;
  logic [15:0] actCtlB = 16'd0;
  logic [3:0]  forceWord = 4'd0;
  logic [1:0]  reloadMode = 2'b11;
  logic        pwmA, pwmB;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pwm_action_qual u_dut (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntUp(cntUp),
    .atZero(atZero), .atPeriod(atPeriod), .cmpA(cmpA), .cmpB(cmpB),
    .actCtlA(actCtlA), .actCtlB(actCtlB), .forceWord(forceWord),
    .reloadMode(reloadMode), .pwmA(pwmA), .pwmB(pwmB)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic setEvents(logic [2:0] mask);
    atZero   = mask[0];
    atPeriod = mask[1];
    cntUp    = 1'b1;
    cntVal   = mask[2] ? 16'd5 : 16'd6;
  endtask

  function automatic logic model(logic cur, logic [1:0] z, logic [1:0] p,
                                 logic [1:0] c, logic [2:0] mask);
    logic [1:0] code;
    code = 2'b00;
    if (mask[2] && c != 2'b00)      code = c;
    else if (mask[1] && p != 2'b00) code = p;
    else if (mask[0] && z != 2'b00) code = z;
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R8 reset pwmA", pwmA, 1'b0);
    check("R8 reset pwmB", pwmB, 1'b0);
    rstN = 1'b1;
    setEvents(3'b000);
    tick();
    check("R8 no force after reset A", pwmA, 1'b0);
    check("R8 no force after reset B", pwmB, 1'b0);

    // R1 R2 R4: sweep of all codes, event subsets, start levels
    for (int init = 0; init < 2; init++) begin
      for (int w = 0; w < 64; w++) begin
        for (int m = 0; m < 8; m++) begin
          logic [1:0] z, p, c;
          logic expA, expB;
          z = w[1:0]; p = w[3:2]; c = w[5:4];
          reloadMode = 2'b11;
          setEvents(3'b000);
          actCtlA = 16'd0; actCtlB = 16'd0;
          forceWord = (init != 0) ? 4'b1010 : 4'b0101;
          tick();
          forceWord = 4'b0000;
          tick();
          check("R9 hold after release A", pwmA, init[0]);
          actCtlA = {6'b0, 2'b11, 2'b00, c, p, z};
          actCtlB = {6'b0, c, 2'b00, 2'b11, p, z};
          setEvents(m[2:0]);
          tick();
          expA = model(init[0], z, p, c, m[2:0]);
          expB = model(init[0], z, p, c, m[2:0]);
          check("R1 R2 R4 sweep A", pwmA, expA);
          check("R1 R2 R4 sweep B", pwmB, expB);
        end
      end
    end

    // R3: equal count while counting down
    reloadMode = 2'b11; setEvents(3'b000); actCtlA = 0; actCtlB = 0;
    forceWord = 4'b0101; tick(); forceWord = 4'b0000; tick();
    actCtlA = 16'h0020; actCtlB = 16'h0200;
    cntVal = 16'd5; cntUp = 1'b0;
    tick();
    check("R3 down match A", pwmA, 1'b0);
    check("R3 down match B", pwmB, 1'b0);
    cntUp = 1'b1;
    tick();
    check("R3 up match A", pwmA, 1'b1);
    check("R3 up match B", pwmB, 1'b1);

    // R5: force overrides events; code 11 is no force
    setEvents(3'b000); actCtlA = 16'h0001; actCtlB = 16'h0001;
    forceWord = 4'b1010;
    setEvents(3'b001);
    tick();
    check("R5 force high beats zero-low A", pwmA, 1'b1);
    check("R5 force high beats zero-low B", pwmB, 1'b1);
    forceWord = 4'b1111;
    tick();
    check("R5 code 11 no force A", pwmA, 1'b0);
    check("R5 code 11 no force B", pwmB, 1'b0);
    forceWord = 4'b1001;
    setEvents(3'b000);
    tick();
    check("R5 split force A low", pwmA, 1'b0);
    check("R5 split force B high", pwmB, 1'b1);

    // R6 R7: deferred reloads
    actCtlA = 0; actCtlB = 0;
    forceWord = 4'b0000; tick();
    forceWord = 4'b0101; tick(); forceWord = 4'b0000; tick();
    reloadMode = 2'b00;
    forceWord = 4'b1010;
    tick();
    check("R7 mode zero no strobe A", pwmA, 1'b0);
    setEvents(3'b010);
    tick();
    check("R6 mode zero ignores period A", pwmA, 1'b0);
    check("R6 mode zero ignores period B", pwmB, 1'b0);
    setEvents(3'b001);
    tick();
    check("R6 mode zero loads at zero A", pwmA, 1'b1);
    check("R6 mode zero loads at zero B", pwmB, 1'b1);
    setEvents(3'b000);
    reloadMode = 2'b01;
    forceWord = 4'b0101;
    setEvents(3'b001);
    tick();
    check("R6 mode period ignores zero A", pwmA, 1'b1);
    setEvents(3'b010);
    tick();
    check("R6 mode period loads A", pwmA, 1'b0);
    check("R6 mode period loads B", pwmB, 1'b0);
    reloadMode = 2'b10;
    forceWord = 4'b1010;
    setEvents(3'b000);
    tick();
    check("R7 mode either no strobe A", pwmA, 1'b0);
    setEvents(3'b001);
    tick();
    check("R6 mode either at zero A", pwmA, 1'b1);
    forceWord = 4'b0101;
    setEvents(3'b010);
    tick();
    check("R6 mode either at period A", pwmA, 1'b0);
    check("R6 mode either at period B", pwmB, 1'b0);
    reloadMode = 2'b11;
    forceWord = 4'b1010;
    setEvents(3'b000);
    tick();
    check("R6 immediate load A", pwmA, 1'b1);
    check("R6 immediate load B", pwmB, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule